// File: doc/BRIEF.md
# Dual-Bank CPU Register File

This block is the architectural register store for an 8-bit processor core. It keeps an accumulator and flag byte, six general bytes (B, C, D, E, H, L) arranged as three 16-bit pairs, a 16-bit program counter, a stack pointer, two index registers, an interrupt vector byte and a refresh counter byte. The accumulator/flag pair and the six general bytes each exist twice, a main copy and an alternate copy. Two bank-select bits say which copy is live.

Two single-cycle commands flip those bank-select bits independently. One flips only the accumulator/flag pair. The other flips only the three general pairs. No data moves during a swap: the live copy is picked by the select bit. The surrounding core reads through a combinational 8-bit port and a combinational 16-bit port. It writes through a registered 8-bit port and a registered 16-bit port. It steps or loads the program counter and pulses an opcode-fetch strobe that advances the refresh counter. The low seven bits of that counter drive the refresh address output. Every control input is a one-cycle synchronous pulse.

Top module: `cpu_regbank`

## Requirements
- R1: The 8-bit port addresses the live byte by a 3-bit code: 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=A, 7=F. `rd8_data` follows `rd8_sel` combinationally. A write on `wr8_en` is visible from the next clock edge.
- R2: The 16-bit port uses a 3-bit code: 0=BC, 1=DE, 2=HL, 3=AF, 4=SP, 5=IX, 6=IY, 7=IR. For codes 0-3 the high byte `[15:8]` is the first-named register (B, D, H, A). Code 7 reads and writes the interrupt vector in `[15:8]` and the refresh counter in `[7:0]`.
- R3: A `swap_af` pulse exchanges the live and alternate A/F pair. The B-L selection is unchanged, and the contents of both copies are kept.
- R4: A `swap_gpr` pulse exchanges BC, DE and HL with their alternates all at once. The A/F selection is unchanged, and the contents of both copies are kept.
- R5: When a write and a swap of the same bank group fall in one cycle, the write lands in the copy that was live before the swap.
- R6: On `pc_inc` the program counter becomes PC+1, wrapping from 0xFFFF to 0x0000. On `pc_load` it takes `pc_load_val`, and a load overrides an increment in the same cycle. With neither pulse it holds.
- R7: While `rst_n` is low, every register is cleared, including PC, the interrupt vector and the refresh counter. Both bank selects point to the main copy.
- R8: Each `opfetch` pulse increments refresh bits [6:0] modulo 128 and leaves bit 7 unchanged. `refresh_addr` shows bits [6:0]. A 16-bit write to code 7 in the same cycle takes precedence over the increment.
- R9: When an 8-bit write and a 16-bit write target the same byte in one cycle, the 8-bit write wins. The other byte of the pair takes the 16-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rd8_sel | input | 3 | 8-bit read code |
| rd8_data | output | 8 | Live byte selected by rd8_sel |
| rd16_sel | input | 3 | 16-bit read code |
| rd16_data | output | 16 | Pair or wide register selected by rd16_sel |
| wr8_en | input | 1 | 8-bit write strobe |
| wr8_sel | input | 3 | 8-bit write code |
| wr8_data | input | 8 | 8-bit write value |
| wr16_en | input | 1 | 16-bit write strobe |
| wr16_sel | input | 3 | 16-bit write code |
| wr16_data | input | 16 | 16-bit write value |
| swap_af | input | 1 | Flip the A/F bank select |
| swap_gpr | input | 1 | Flip the B-L bank select |
| pc_inc | input | 1 | Step the program counter |
| pc_load | input | 1 | Load the program counter |
| pc_load_val | input | 16 | Jump target |
| opfetch | input | 1 | Opcode fetch strobe, steps refresh counter |
| pc_addr | output | 16 | Current program counter |
| refresh_addr | output | 7 | Refresh counter bits [6:0] |

## Verification
Several pairs of functions can land in the same cycle. The bench provokes each pair by raising both strobes between the same two clock edges, then judges the outcome at the ports on the following cycle. A write together with a swap of its own group is judged by reading the byte now live, which must hold the old alternate value. It then swaps back and reads again, and the byte must now hold the written value. The other pairs are judged the same way: a PC load with an increment, an opcode fetch with an IR write, and overlapping 8-bit and 16-bit writes.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    parameter int DW     = 8;
    parameter int AW     = 16;
    parameter int RFW    = 7;
    parameter int NREG   = 8;
    parameter int NBANK  = 2;
    localparam int SELW  = $clog2(NREG);
    localparam int PW    = 2 * DW;
    localparam int NPAIR = NREG / 2;
    localparam int AF_BASE = 6;

    typedef enum logic [SELW-1:0] {
        PR_BC = 3'd0,
        PR_DE = 3'd1,
        PR_HL = 3'd2,
        PR_AF = 3'd3,
        PR_SP = 3'd4,
        PR_IX = 3'd5,
        PR_IY = 3'd6,
        PR_IR = 3'd7
    } pair_e;

    typedef struct packed {
        logic [NREG-1:0][NBANK-1:0][DW-1:0] regs;
        logic                               asel;
        logic                               gsel;
    } store_t;

    typedef struct packed {
        logic [AW-1:0] pc;
        logic [AW-1:0] sp;
        logic [AW-1:0] ix;
        logic [AW-1:0] iy;
        logic [DW-1:0] iv;
        logic [DW-1:0] rf;
    } ctl_t;

endpackage

// File: rtl/rb_pair_store.sv
module rb_pair_store
    import regbank_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr8_en,
    input  logic [SELW-1:0]          wr8_sel,
    input  logic [DW-1:0]            wr8_data,
    input  logic                     wr16_en,
    input  logic [SELW-1:0]          wr16_sel,
    input  logic [PW-1:0]            wr16_data,
    input  logic                     swap_af,
    input  logic                     swap_gpr,
    output logic [NREG-1:0][DW-1:0]  view
);

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int c = 0; c < NREG; c++) begin
            // writes use the select as it stood before any swap this cycle
            if (wr16_en && int'(wr16_sel) < NPAIR && int'(wr16_sel) == c / 2) begin
                st_d.regs[c][(c >= AF_BASE) ? st_q.asel : st_q.gsel] =
                    (c % 2 == 0) ? wr16_data[PW-1:DW] : wr16_data[DW-1:0];
            end
            if (wr8_en && int'(wr8_sel) == c) begin
                st_d.regs[c][(c >= AF_BASE) ? st_q.asel : st_q.gsel] = wr8_data;
            end
        end
        st_d.asel = st_q.asel ^ swap_af;
        st_d.gsel = st_q.gsel ^ swap_gpr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_view
        if (g >= AF_BASE) begin : g_acc
            assign view[g] = st_q.regs[g][st_q.asel];
        end else begin : g_gen
            assign view[g] = st_q.regs[g][st_q.gsel];
        end
    end

endmodule

// File: rtl/rb_ctl_regs.sv
module rb_ctl_regs
    import regbank_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr16_en,
    input  logic [SELW-1:0] wr16_sel,
    input  logic [PW-1:0]   wr16_data,
    input  logic            pc_inc,
    input  logic            pc_load,
    input  logic [AW-1:0]   pc_load_val,
    input  logic            opfetch,
    output ctl_t            ctl
);

    ctl_t cr_d, cr_q;

    always_comb begin
        cr_d = cr_q;
        if (pc_load)     cr_d.pc = pc_load_val;
        else if (pc_inc) cr_d.pc = cr_q.pc + AW'(1);
        if (opfetch) cr_d.rf[RFW-1:0] = cr_q.rf[RFW-1:0] + RFW'(1);
        if (wr16_en) begin
            case (pair_e'(wr16_sel))
                PR_SP:   cr_d.sp = wr16_data;
                PR_IX:   cr_d.ix = wr16_data;
                PR_IY:   cr_d.iy = wr16_data;
                PR_IR:   {cr_d.iv, cr_d.rf} = wr16_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cr_q <= '0;
        else        cr_q <= cr_d;
    end

    assign ctl = cr_q;

endmodule

// File: rtl/cpu_regbank.sv
module cpu_regbank
    import regbank_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      rd8_sel,
    output logic [7:0]      rd8_data,
    input  logic [2:0]      rd16_sel,
    output logic [15:0]     rd16_data,
    input  logic            wr8_en,
    input  logic [2:0]      wr8_sel,
    input  logic [7:0]      wr8_data,
    input  logic            wr16_en,
    input  logic [2:0]      wr16_sel,
    input  logic [15:0]     wr16_data,
    input  logic            swap_af,
    input  logic            swap_gpr,
    input  logic            pc_inc,
    input  logic            pc_load,
    input  logic [15:0]     pc_load_val,
    input  logic            opfetch,
    output logic [15:0]     pc_addr,
    output logic [6:0]      refresh_addr
);

    logic [NREG-1:0][DW-1:0] view;
    ctl_t                    ctl;

    rb_pair_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr8_en    (wr8_en),
        .wr8_sel   (wr8_sel),
        .wr8_data  (wr8_data),
        .wr16_en   (wr16_en),
        .wr16_sel  (wr16_sel),
        .wr16_data (wr16_data),
        .swap_af   (swap_af),
        .swap_gpr  (swap_gpr),
        .view      (view)
    );

    rb_ctl_regs u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr16_en     (wr16_en),
        .wr16_sel    (wr16_sel),
        .wr16_data   (wr16_data),
        .pc_inc      (pc_inc),
        .pc_load     (pc_load),
        .pc_load_val (pc_load_val),
        .opfetch     (opfetch),
        .ctl         (ctl)
    );

    assign rd8_data = view[rd8_sel];

    always_comb begin
        case (pair_e'(rd16_sel))
            PR_SP:   rd16_data = ctl.sp;
            PR_IX:   rd16_data = ctl.ix;
            PR_IY:   rd16_data = ctl.iy;
            PR_IR:   rd16_data = {ctl.iv, ctl.rf};
            default: rd16_data = {view[{rd16_sel[1:0], 1'b0}], view[{rd16_sel[1:0], 1'b1}]};
        endcase
    end

    assign pc_addr      = ctl.pc;
    assign refresh_addr = ctl.rf[RFW-1:0];

endmodule

// File: rtl/rb_checker.sv
module rb_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        wr16_en,
    input logic [2:0]  wr16_sel,
    input logic        pc_inc,
    input logic        pc_load,
    input logic [15:0] pc_load_val,
    input logic        opfetch,
    input logic [15:0] pc_addr,
    input logic [6:0]  refresh_addr
);

    p_pc_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> pc_addr == $past(pc_load_val));

    p_pc_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_inc && !pc_load) |=> pc_addr == $past(pc_addr) + 16'd1);

    p_pc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_inc && !pc_load) |=> $stable(pc_addr));

    p_refresh_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (opfetch && !(wr16_en && wr16_sel == 3'd7)) |=> refresh_addr == $past(refresh_addr) + 7'd1);

    p_refresh_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!opfetch && !wr16_en) |=> $stable(refresh_addr));

    p_reset_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pc_addr == 16'd0 && refresh_addr == 7'd0));

endmodule

bind cpu_regbank rb_checker chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr16_en      (wr16_en),
    .wr16_sel     (wr16_sel),
    .pc_inc       (pc_inc),
    .pc_load      (pc_load),
    .pc_load_val  (pc_load_val),
    .opfetch      (opfetch),
    .pc_addr      (pc_addr),
    .refresh_addr (refresh_addr)
);

// File: tb/cpu_regbank_tb_top.sv
`timescale 1ns/1ps
module cpu_regbank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  rd8_sel = '0;
    logic [7:0]  rd8_data;
    logic [2:0]  rd16_sel = '0;
    logic [15:0] rd16_data;
    logic        wr8_en = 1'b0;
    logic [2:0]  wr8_sel = '0;
    logic [7:0]  wr8_data = '0;
    logic        wr16_en = 1'b0;
    logic [2:0]  wr16_sel = '0;
    logic [15:0] wr16_data = '0;
    logic        swap_af = 1'b0;
    logic        swap_gpr = 1'b0;
    logic        pc_inc = 1'b0;
    logic        pc_load = 1'b0;
    logic [15:0] pc_load_val = '0;
    logic        opfetch = 1'b0;
    logic [15:0] pc_addr;
    logic [6:0]  refresh_addr;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    cpu_regbank dut_i (.*);

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_ctl();
        wr8_en = 0; wr16_en = 0; swap_af = 0; swap_gpr = 0;
        pc_inc = 0; pc_load = 0; opfetch = 0;
    endtask

    // called at a falling edge; returns at the next falling edge with controls cleared
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        clear_ctl();
    endtask

    task automatic w8(input logic [2:0] s, input logic [7:0] v);
        wr8_en = 1; wr8_sel = s; wr8_data = v; cyc();
    endtask

    task automatic w16(input logic [2:0] s, input logic [15:0] v);
        wr16_en = 1; wr16_sel = s; wr16_data = v; cyc();
    endtask

    task automatic c8(input string tag, input logic [2:0] s, input logic [7:0] exp);
        rd8_sel = s; #0.2;
        chk(tag, {8'h00, rd8_data}, {8'h00, exp});
    endtask

    task automatic c16(input string tag, input logic [2:0] s, input logic [15:0] exp);
        rd16_sel = s; #0.2;
        chk(tag, rd16_data, exp);
    endtask

    task automatic t_reset();
        chk("R7 pc after reset", pc_addr, 16'h0000);
        chk("R7 refresh after reset", {9'd0, refresh_addr}, 16'h0000);
        c16("R7 IR after reset", 3'd7, 16'h0000);
        c16("R7 BC after reset", 3'd0, 16'h0000);
        c16("R7 AF after reset", 3'd3, 16'h0000);
    endtask

    task automatic t_rw8();
        for (int i = 0; i < 8; i++) w8(3'(i), 8'h10 + 8'(i));
        for (int i = 0; i < 8; i++) c8("R1 byte readback", 3'(i), 8'h10 + 8'(i));
        c16("R2 BC high=B", 3'd0, 16'h1011);
        c16("R2 HL high=H", 3'd4 - 3'd2, 16'h1415);
        c16("R2 AF high=A", 3'd3, 16'h1617);
    endtask

    task automatic t_rw16();
        w16(3'd4, 16'h1234);
        w16(3'd5, 16'h5678);
        w16(3'd6, 16'h9ABC);
        w16(3'd7, 16'h8005);
        c16("R2 SP", 3'd4, 16'h1234);
        c16("R2 IX", 3'd5, 16'h5678);
        c16("R2 IY", 3'd6, 16'h9ABC);
        c16("R2 IR", 3'd7, 16'h8005);
        chk("R8 refresh shows R[6:0]", {9'd0, refresh_addr}, 16'h0005);
        w16(3'd1, 16'hD1E1);
        c8("R2 DE write high to D", 3'd2, 8'hD1);
        c8("R2 DE write low to E", 3'd3, 8'hE1);
        w16(3'd1, 16'h1213);
    endtask

    task automatic t_swap_af();
        swap_af = 1; cyc();
        c8("R3 alt A empty", 3'd6, 8'h00);
        c8("R3 alt F empty", 3'd7, 8'h00);
        c8("R3 B unaffected", 3'd0, 8'h10);
        w8(3'd6, 8'h33);
        swap_af = 1; cyc();
        c8("R3 main A kept", 3'd6, 8'h16);
        swap_af = 1; cyc();
        c8("R3 alt A kept", 3'd6, 8'h33);
        swap_af = 1; cyc();
    endtask

    task automatic t_swap_gpr();
        swap_gpr = 1; cyc();
        c8("R4 alt B empty", 3'd0, 8'h00);
        c16("R4 alt HL empty", 3'd2, 16'h0000);
        c8("R4 A unaffected", 3'd6, 8'h16);
        w8(3'd4, 8'h77);
        swap_gpr = 1; cyc();
        c8("R4 main H kept", 3'd4, 8'h14);
        c16("R4 main DE kept", 3'd1, 16'h1213);
        swap_gpr = 1; cyc();
        c8("R4 alt H kept", 3'd4, 8'h77);
        swap_gpr = 1; cyc();
    endtask

    task automatic t_swap_write();
        wr8_en = 1; wr8_sel = 3'd0; wr8_data = 8'h5A; swap_gpr = 1; cyc();
        c8("R5 B write not in new bank", 3'd0, 8'h00);
        swap_gpr = 1; cyc();
        c8("R5 B write in old bank", 3'd0, 8'h5A);
        wr8_en = 1; wr8_sel = 3'd6; wr8_data = 8'h99; swap_af = 1; cyc();
        c8("R5 A write not in new bank", 3'd6, 8'h33);
        swap_af = 1; cyc();
        c8("R5 A write in old bank", 3'd6, 8'h99);
    endtask

    task automatic t_pc();
        pc_load = 1; pc_load_val = 16'hFFFE; cyc();
        chk("R6 pc load", pc_addr, 16'hFFFE);
        pc_inc = 1; cyc();
        chk("R6 pc inc", pc_addr, 16'hFFFF);
        pc_inc = 1; cyc();
        chk("R6 pc wrap", pc_addr, 16'h0000);
        cyc();
        chk("R6 pc hold", pc_addr, 16'h0000);
        pc_inc = 1; pc_load = 1; pc_load_val = 16'h4321; cyc();
        chk("R6 load beats inc", pc_addr, 16'h4321);
    endtask

    task automatic t_refresh();
        w16(3'd7, 16'h807E);
        opfetch = 1; cyc();
        c16("R8 fetch step", 3'd7, 16'h807F);
        opfetch = 1; cyc();
        c16("R8 wrap keeps bit7", 3'd7, 16'h8000);
        chk("R8 refresh after wrap", {9'd0, refresh_addr}, 16'h0000);
        opfetch = 1; wr16_en = 1; wr16_sel = 3'd7; wr16_data = 16'h0042; cyc();
        c16("R8 write beats fetch", 3'd7, 16'h0042);
    endtask

    task automatic t_overlap();
        wr16_en = 1; wr16_sel = 3'd0; wr16_data = 16'hAAAA;
        wr8_en = 1; wr8_sel = 3'd1; wr8_data = 8'h55; cyc();
        c16("R9 byte write wins", 3'd0, 16'hAA55);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rw8();
        t_rw16();
        t_swap_af();
        t_swap_gpr();
        t_swap_write();
        t_pc();
        t_refresh();
        t_overlap();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule